// File: doc/BRIEF.md
# Segmented Mismatch-Scrambling DAC Encoder

This block turns the output of a nine-level flash quantizer into drive bits for ten one-bit unit DACs. Eight DACs carry a full step and two carry a half step. It also adds a one-bit gain-calibration dither, which moves the combined analog level by half a step. The total level is therefore `2*code + dither` in half-step units, and the weighted count of asserted DAC bits reproduces it exactly in every sample.

A segmenting switch first divides that level between the half-step pair and the full-step group. Binary trees of switching nodes then divide each share down to single DACs: one node for the half-step pair, and three layers of four, two and one nodes for the full-step group. Whenever a switch must split an odd value, it rounds one way or the other. The direction is a signed choice drawn from two fresh random bits per switch per sample. All nine choices go out as signed two-bit codes, so that downstream calibration logic can correlate against them and cancel the resulting mismatch noise.

Samples enter and leave through valid/ready handshakes, with one register stage between them. An input is taken on any edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output word and every output bit are frozen and no new input is taken.

Top module: `dem_scramble_enc`

## Requirements
- R1: The level is `w = 2*c + gain_dither`, where `c` is `flash_code` saturated to 8, so codes 9 to 15 behave like code 8.
- R2: For every accepted sample, `2*popcount(dac_full) + popcount(dac_half)` equals `w`.
- R3: The segment sequence (pair 0 of `seq_codes`) is zero when `w` is odd. When `w` is even and nonzero it is +1 if `rnd_bits[0]^rnd_bits[1]` is 0, and -1 otherwise. The half-step pair receives `1 - s` and the full-step group receives `(w - 1 + s)/2`.
- R4: When `w` is 0, the segment sequence is forced to +1 whatever the random bits, so that neither group goes negative.
- R5: Each tree node with input `x` takes its own pair `k` of random bits and sets `s = 0` for even `x`, or `±1` from `rnd_bits[2k]^rnd_bits[2k+1]` (0 gives +1) for odd `x`.
  - The upper child receives `(x+s)/2` and the lower child receives `(x-s)/2`.
  - Pair 1 belongs to the half-step node, whose upper child drives `dac_half[1]`.
  - Pairs 2 to 5 belong to the lowest full-step nodes, pair `2+i` driving `dac_full[2i+1]` (upper) and `dac_full[2i]`.
  - Pairs 6 and 7 belong to the middle nodes, pair 7 feeding bits 7..4.
  - Pair 8 belongs to the root, whose upper child feeds pairs 7, 5 and 4.
- R6: Sequence codes are 2'b00 for zero, 2'b01 for +1 and 2'b11 for -1. 2'b10 never appears on a valid output.
- R7: `in_ready = !out_valid || out_ready`. An accepted sample appears on the outputs with `out_valid` high after exactly one clock edge.
- R8: While `out_valid` is high and `out_ready` is low, the outputs hold and `in_ready` is low.
- R9: After reset, `out_valid`, `dac_full`, `dac_half` and `seq_codes` are all zero.
- R10: The random choices come only from the `rnd_bits` present at the accepting edge. Changing them between samples changes the choices for the same level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take an input sample |
| flash_code | input | 4 | Flash quantizer code, 0 to 8 |
| gain_dither | input | 1 | Gain-calibration dither bit |
| rnd_bits | input | 18 | Two fresh random bits per switch |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output sample |
| dac_full | output | 8 | Full-step DAC drive bits |
| dac_half | output | 2 | Half-step DAC drive bits |
| seq_codes | output | 18 | Nine signed two-bit switching sequences |

## Verification
Two things can happen on the same edge: draining a stalled output word and taking the input that waited behind it. The stall-release scenario holds `out_ready` low for several cycles with a fresh sample on the input. It then raises `out_ready` and requires the new sample to appear on the very next sample slot with the old one gone. The sweep streams every code and dither value back to back against random bit patterns. Each sample is judged against a model built from the splitting rules, and also against the weighted-sum identity.

// File: rtl/dem_pkg.sv
package dem_pkg;
  typedef enum logic [1:0] {
    SEQ_ZERO = 2'b00,
    SEQ_POS  = 2'b01,
    SEQ_NEG  = 2'b11
  } seq_code_e;

  // the two random bits are folded so a biased single bit cannot bias the sign
  function automatic seq_code_e pick_sign(input logic [1:0] r);
    return (r[0] ^ r[1]) ? SEQ_NEG : SEQ_POS;
  endfunction
endpackage

// File: rtl/dem_split_node.sv
module dem_split_node #(
  parameter int IN_W = 4
) (
  input  logic [IN_W-1:0] x_i,
  input  logic [1:0]      rnd_i,
  output logic [IN_W-2:0] hi_o,
  output logic [IN_W-2:0] lo_o,
  output logic [1:0]      code_o
);
  import dem_pkg::*;

  localparam int OUT_W = IN_W - 1;

  seq_code_e  code;
  logic [OUT_W-1:0] half_floor;

  always_comb begin
    code       = x_i[0] ? pick_sign(rnd_i) : SEQ_ZERO;
    half_floor = x_i[IN_W-1:1];
    hi_o       = half_floor + OUT_W'(code == SEQ_POS);
    lo_o       = half_floor + OUT_W'(code == SEQ_NEG);
    code_o     = code;
  end
endmodule

// File: rtl/dem_tree.sv
module dem_tree #(
  parameter int DEPTH = 3
) (
  input  logic [DEPTH:0]               x_i,
  input  logic [2*(2**DEPTH-1)-1:0]    rnd_i,
  output logic [2**DEPTH-1:0]          bits_o,
  output logic [2*(2**DEPTH-1)-1:0]    codes_o
);
  localparam int N_LEAF = 2**DEPTH;

  // level 0 holds the root value; level DEPTH holds one-bit leaf values.
  // position 0 in a level is the upper-most branch.
  for (genvar lv = 0; lv <= DEPTH; lv++) begin : g_lv
    localparam int W = DEPTH - lv + 1;
    logic [W-1:0] val [2**lv];

    if (lv == 0) begin : g_root
      assign val[0] = x_i;
    end else begin : g_nodes
      for (genvar p = 0; p < 2**(lv-1); p++) begin : g_nd
        // flat index = 2**DEPTH - 1 - heap index of the parent node
        localparam int FLAT = N_LEAF - 1 - (2**(lv-1) + p);
        dem_split_node #(.IN_W(W + 1)) u_nd (
          .x_i   (g_lv[lv-1].val[p]),
          .rnd_i (rnd_i[2*FLAT +: 2]),
          .hi_o  (val[2*p]),
          .lo_o  (val[2*p+1]),
          .code_o(codes_o[2*FLAT +: 2])
        );
      end
    end

    if (lv == DEPTH) begin : g_leaf
      for (genvar q = 0; q < N_LEAF; q++) begin : g_bit
        assign bits_o[N_LEAF-1-q] = val[q][0];
      end
    end
  end
endmodule

// File: rtl/dem_seg_switch.sv
module dem_seg_switch #(
  parameter int LVL_W  = 5,
  parameter int FULL_W = 4,
  parameter int HALF_W = 2
) (
  input  logic [LVL_W-1:0]  w_i,
  input  logic [1:0]        rnd_i,
  output logic [FULL_W-1:0] full_o,
  output logic [HALF_W-1:0] half_o,
  output logic [1:0]        code_o
);
  import dem_pkg::*;

  seq_code_e code;

  always_comb begin
    if (w_i[0])          code = SEQ_ZERO;
    else if (w_i == '0)  code = SEQ_POS;   // keep both shares non-negative
    else                 code = pick_sign(rnd_i);

    unique case (code)
      SEQ_POS: half_o = HALF_W'(0);
      SEQ_NEG: half_o = HALF_W'(2);
      default: half_o = HALF_W'(1);
    endcase

    full_o = w_i[FULL_W:1] - FULL_W'(code == SEQ_NEG);
    code_o = code;
  end
endmodule

// File: rtl/dem_scramble_enc.sv
module dem_scramble_enc #(
  parameter int FULL_DEPTH = 3,
  parameter int HALF_DEPTH = 1,
  parameter int N_FULL = 2**FULL_DEPTH,
  parameter int N_HALF = 2**HALF_DEPTH,
  parameter int N_SEQ  = N_FULL + N_HALF - 1,
  parameter int CODE_W = $clog2(N_FULL + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [CODE_W-1:0]    flash_code,
  input  logic                 gain_dither,
  input  logic [2*N_SEQ-1:0]   rnd_bits,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [N_FULL-1:0]    dac_full,
  output logic [N_HALF-1:0]    dac_half,
  output logic [2*N_SEQ-1:0]   seq_codes
);
  localparam int LVL_W   = CODE_W + 1;
  localparam int FULL_W  = FULL_DEPTH + 1;
  localparam int HALF_W  = HALF_DEPTH + 1;
  localparam int HSEQ    = N_HALF - 1;
  localparam int FSEQ    = N_FULL - 1;

  logic [CODE_W-1:0]  code_sat;
  logic [LVL_W-1:0]   level;
  logic [FULL_W-1:0]  full_share;
  logic [HALF_W-1:0]  half_share;
  logic [N_FULL-1:0]  full_bits;
  logic [N_HALF-1:0]  half_bits;
  logic [2*N_SEQ-1:0] codes;
  logic               take;

  assign code_sat = (flash_code > CODE_W'(N_FULL)) ? CODE_W'(N_FULL) : flash_code;
  assign level    = {code_sat, gain_dither};

  dem_seg_switch #(.LVL_W(LVL_W), .FULL_W(FULL_W), .HALF_W(HALF_W)) u_seg (
    .w_i   (level),
    .rnd_i (rnd_bits[1:0]),
    .full_o(full_share),
    .half_o(half_share),
    .code_o(codes[1:0])
  );

  dem_tree #(.DEPTH(HALF_DEPTH)) u_half (
    .x_i    (half_share),
    .rnd_i  (rnd_bits[2 +: 2*HSEQ]),
    .bits_o (half_bits),
    .codes_o(codes[2 +: 2*HSEQ])
  );

  dem_tree #(.DEPTH(FULL_DEPTH)) u_full (
    .x_i    (full_share),
    .rnd_i  (rnd_bits[2+2*HSEQ +: 2*FSEQ]),
    .bits_o (full_bits),
    .codes_o(codes[2+2*HSEQ +: 2*FSEQ])
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dac_full  <= '0;
      dac_half  <= '0;
      seq_codes <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        dac_full  <= full_bits;
        dac_half  <= half_bits;
        seq_codes <= codes;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dem_scramble_enc_chk.sv
module dem_scramble_enc_chk #(
  parameter int N_FULL = 8,
  parameter int N_HALF = 2,
  parameter int N_SEQ  = 9,
  parameter int CODE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [CODE_W-1:0]  flash_code,
  input logic               gain_dither,
  input logic               out_valid,
  input logic               out_ready,
  input logic [N_FULL-1:0]  dac_full,
  input logic [N_HALF-1:0]  dac_half,
  input logic [2*N_SEQ-1:0] seq_codes
);
  int unsigned out_sum;
  int unsigned in_lvl;
  assign out_sum = 2 * $countones(dac_full) + $countones(dac_half);
  assign in_lvl  = 2 * ((int'(flash_code) > N_FULL) ? N_FULL : int'(flash_code)) + int'(gain_dither);

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready) |-> out_valid && (out_sum == $past(in_lvl))); // R2

  AST_SEG_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((seq_codes[1:0] == 2'b00) == out_sum[0])); // R3

  AST_EMPTY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_sum == 0) |-> seq_codes[1:0] == 2'b01); // R4

  AST_ROOT_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((seq_codes[2*N_SEQ-1 -: 2] == 2'b00) == !($countones(dac_full) % 2))); // R5

  for (genvar k = 0; k < N_SEQ; k++) begin : g_legal
    AST_SEQ_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> seq_codes[2*k +: 2] != 2'b10); // R6
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(dac_full) && $stable(dac_half) && $stable(seq_codes)); // R8

  AST_STALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8
endmodule

bind dem_scramble_enc dem_scramble_enc_chk #(
  .N_FULL(N_FULL), .N_HALF(N_HALF), .N_SEQ(N_SEQ), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .flash_code(flash_code), .gain_dither(gain_dither),
  .out_valid(out_valid), .out_ready(out_ready),
  .dac_full(dac_full), .dac_half(dac_half), .seq_codes(seq_codes)
);

// File: tb/dem_scramble_enc_tb_top.sv
module dem_scramble_enc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 8;
  localparam int NH = 2;
  localparam int NS = 9;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [CW-1:0] flash_code = '0;
  logic gain_dither = 1'b0;
  logic [2*NS-1:0] rnd_bits = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [NF-1:0] dac_full;
  logic [NH-1:0] dac_half;
  logic [2*NS-1:0] seq_codes;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dem_scramble_enc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .flash_code(flash_code), .gain_dither(gain_dither), .rnd_bits(rnd_bits),
    .out_valid(out_valid), .out_ready(out_ready),
    .dac_full(dac_full), .dac_half(dac_half), .seq_codes(seq_codes)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sgn(input logic [2*NS-1:0] rb, input int k);
    return (rb[2*k] ^ rb[2*k+1]) ? -1 : 1;
  endfunction

  function automatic logic [1:0] enc(input int s);
    return (s == 0) ? 2'b00 : (s > 0) ? 2'b01 : 2'b11;
  endfunction

  // expected outputs built from the splitting rules of R1, R3, R4, R5, R6
  task automatic model(input int code, input int d, input logic [2*NS-1:0] rb,
                       output logic [NF-1:0] ef, output logic [NH-1:0] eh,
                       output logic [2*NS-1:0] es);
    int c, w, s, h, f, x;
    int hv [1:15];
    c = (code > 8) ? 8 : code;
    w = 2 * c + d;
    es = '0;
    if (w % 2 == 1) s = 0;
    else if (w == 0) s = 1;
    else s = sgn(rb, 0);
    es[1:0] = enc(s);
    h = 1 - s;
    f = (w - 1 + s) / 2;
    s = (h % 2 == 1) ? sgn(rb, 1) : 0;
    es[3:2] = enc(s);
    eh[1] = ((h + s) / 2) != 0;
    eh[0] = ((h - s) / 2) != 0;
    hv[1] = f;
    for (int n = 1; n < 8; n++) begin
      x = hv[n];
      s = (x % 2 == 1) ? sgn(rb, 9 - n) : 0;
      es[2*(9-n) +: 2] = enc(s);
      hv[2*n]   = (x + s) / 2;
      hv[2*n+1] = (x - s) / 2;
    end
    for (int n = 8; n < 16; n++) ef[15-n] = hv[n] != 0;
  endtask

  task automatic drive(input int code, input int d, input logic [2*NS-1:0] rb);
    flash_code  = CW'(code);
    gain_dither = d[0];
    rnd_bits    = rb;
    in_valid    = 1'b1;
  endtask

  task automatic judge(input int code, input int d, input logic [2*NS-1:0] rb, input string tag);
    logic [NF-1:0] ef; logic [NH-1:0] eh; logic [2*NS-1:0] es;
    int c, sum;
    bit legal;
    model(code, d, rb, ef, eh, es);
    c = (code > 8) ? 8 : code;
    sum = 2 * $countones(dac_full) + $countones(dac_half);
    legal = 1'b1;
    for (int k = 0; k < NS; k++) if (seq_codes[2*k +: 2] == 2'b10) legal = 1'b0;
    check(out_valid === 1'b1, {tag, " R7 out_valid"}, out_valid, 1);
    check(sum == 2*c + d, {tag, " R2 weighted sum"}, sum, 2*c + d);
    check(dac_full === ef, {tag, " R5 full bits"}, dac_full, ef);
    check(dac_half === eh, {tag, " R3 half bits"}, dac_half, eh);
    check(seq_codes === es, {tag, " R5 sequences"}, seq_codes, es);
    check(legal, {tag, " R6 legal codes"}, seq_codes, es);
  endtask

  task automatic t_reset();
    check(out_valid === 1'b0, "R9 out_valid", out_valid, 0);
    check(dac_full === '0 && dac_half === '0, "R9 dac bits", {dac_full, dac_half}, 0);
    check(seq_codes === '0, "R9 seq_codes", seq_codes, 0);
    check(in_ready === 1'b1, "R7 in_ready idle", in_ready, 1);
  endtask

  task automatic t_sweep();
    logic [2*NS-1:0] rb;
    out_ready = 1'b1;
    for (int code = 0; code <= 8; code++)
      for (int d = 0; d < 2; d++)
        for (int r = 0; r < 24; r++) begin
          rb = (r == 0) ? '0 : (r == 1) ? '1 : (2*NS)'($urandom);
          drive(code, d, rb);
          @(negedge clk);
          judge(code, d, rb, "sweep");
        end
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_clamp();
    logic [2*NS-1:0] rb;
    for (int code = 9; code < 16; code++) begin
      rb = (2*NS)'($urandom);
      drive(code, code % 2, rb);
      @(negedge clk);
      judge(code, code % 2, rb, "R1 clamp");
    end
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_empty_edge();
    logic [2*NS-1:0] rb;
    for (int r = 0; r < 4; r++) begin
      rb = (2*NS)'(r);
      drive(0, 0, rb);
      @(negedge clk);
      check(seq_codes[1:0] === 2'b01, "R4 forced +1", seq_codes[1:0], 1);
      check(dac_half === '0 && dac_full === '0, "R4 all off", {dac_full, dac_half}, 0);
    end
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_fresh();
    drive(4, 0, 18'b00);
    @(negedge clk);
    check(seq_codes[1:0] === 2'b01, "R10 seg sign pair 00", seq_codes[1:0], 1);
    check(dac_half === 2'b00, "R3 half share 0", dac_half, 0);
    drive(4, 0, 18'b01);
    @(negedge clk);
    check(seq_codes[1:0] === 2'b11, "R10 seg sign pair 01", seq_codes[1:0], 3);
    check(dac_half === 2'b11, "R3 half share 2", dac_half, 3);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_stall();
    logic [2*NS-1:0] ra, rb2;
    ra = (2*NS)'($urandom);
    rb2 = (2*NS)'($urandom);
    out_ready = 1'b1;
    drive(5, 1, ra);
    @(negedge clk);
    judge(5, 1, ra, "stall A");
    out_ready = 1'b0;
    drive(2, 0, rb2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      judge(5, 1, ra, "R8 stall hold");
      check(in_ready === 1'b0, "R8 in_ready low", in_ready, 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    judge(2, 0, rb2, "R7 release B");
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R7 drained", out_valid, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_clamp();
    t_empty_edge();
    t_fresh();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule